// File: doc/BRIEF.md
# Reconfigurable Vector Register File

This block is the operand store of a single-lane 64-bit vector unit. It holds a fixed pool of 256 entries of 64 bits. At run time this pool is cut into registers of a selectable shape: 32 registers of 8 elements, 16 registers of 16 elements, or 8 registers of 32 elements. Every access names a register and an element. The block turns this pair into a physical entry with the formula register times elements-per-register plus element. It flags any pair that falls outside the current shape.

The same file serves scalar and vector operands. In one cycle it serves the four operand reads and two result writes of two ALU operations, one load writeback and one store-data read. Read ports 0 to 3 feed the ALUs and read port 4 feeds the store path. Write ports 0 and 1 take ALU results and write port 2 takes load data. A shape change is applied only in a cycle in which no port is in use. Storage is not cleared by a shape change, so existing entries are simply seen under the new mapping. The current elements-per-register value is reported as the vector length limit.

Top module: `vrf_top`

## Requirements
- R1: During reset and in the first cycle after it, `vlmax` is 8 (32 registers of 8 elements), every `rd_data` lane is 0, and every `rd_err` and `wr_err` bit is 0.
- R2: A `cfg_set` pulse with `cfg_code` of 3, 4 or 5 in an idle cycle sets elements-per-register to 2^`cfg_code`. `vlmax` shows the new value one cycle later.
- R3: A `cfg_set` is ignored in a cycle where any `rd_en` or `wr_en` bit is high. A `cfg_set` with `cfg_code` outside 3..5 is also ignored.
- R4: The physical entry for (register, element) is register * `vlmax` + element. Data written under one shape is read back under another at the same physical entry.
- R5: An enabled, in-range read returns the entry's 64-bit value on `rd_data` of that port one cycle after `rd_en`.
- R6: A read whose register is at or above 256/`vlmax`, or whose element is at or above `vlmax`, raises `rd_err` of that port one cycle later, with `rd_data` of that port equal to 0.
- R7: A write that is out of range in the same sense is suppressed, leaving every entry unchanged. It raises `wr_err` of that port one cycle later.
- R8: A read of an entry that is being written in the same cycle returns the data being written.
- R9: When several write ports hit the same entry in one cycle, the highest-numbered port wins. The load port (2) beats both ALU ports, and port 1 beats port 0. Forwarding to a read follows the same order.
- R10: All five read ports and all three write ports work in the same cycle on independent entries.
- R11: A read port with `rd_en` low keeps its previous `rd_data` and drives `rd_err` low in the next cycle. A write port with `wr_en` low drives `wr_err` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_set | input | 1 | Request a register shape change |
| cfg_code | input | 3 | log2 of elements per register (3..5) |
| vlmax | output | 6 | Current elements per register (vector length limit) |
| rd_en | input | 5 | Read enables; ports 0-3 ALU operands, port 4 store data |
| rd_reg | input | 5x5 | Register number per read port |
| rd_elem | input | 5x5 | Element index per read port |
| rd_data | output | 5x64 | Registered read data per port |
| rd_err | output | 5 | Registered out-of-range flag per read port |
| wr_en | input | 3 | Write enables; ports 0-1 ALU results, port 2 load writeback |
| wr_reg | input | 3x5 | Register number per write port |
| wr_elem | input | 3x5 | Element index per write port |
| wr_data | input | 3x64 | Write data per port |
| wr_err | output | 3 | Registered out-of-range flag per write port |

## Verification
Every result of this block arrives exactly one clock edge after its stimulus. This covers read data and read errors on the edge after `rd_en`, write errors on the edge after `wr_en`, and the new `vlmax` on the edge after an accepted `cfg_set`. A write becomes visible to a plain read issued on the following cycle, or to a same-cycle read through forwarding. The bench drives each stimulus just after a rising edge and samples the outputs just after the next rising edge, so each check lands on the single cycle its result is due. Hold and ignore cases are checked one further cycle on, after the same edge.

// File: rtl/vrf_pkg.sv
package vrf_pkg;

  // True when a shape code lies inside the supported window.
  function automatic logic code_ok(input int code, input int lo, input int hi);
    return (code >= lo) && (code <= hi);
  endfunction

endpackage

// File: rtl/vrf_cfg.sv
module vrf_cfg #(
  parameter int CODE_W    = 3,
  parameter int VL_W      = 6,
  parameter int LOG2E_MIN = 3,
  parameter int LOG2E_MAX = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_req,
  input  logic              busy,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] log2e_q,
  output logic [VL_W-1:0]   vlmax_q
);

  logic accept;

  always_comb begin
    accept = set_req && !busy &&
             vrf_pkg::code_ok(int'(code), LOG2E_MIN, LOG2E_MAX);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      log2e_q <= CODE_W'(LOG2E_MIN);
      vlmax_q <= VL_W'(1) << LOG2E_MIN;
    end else if (accept) begin
      log2e_q <= code;
      vlmax_q <= VL_W'(1) << code;
    end
  end

endmodule

// File: rtl/vrf_addr_map.sv
module vrf_addr_map #(
  parameter int ADDR_W = 8,
  parameter int REG_W  = 5,
  parameter int ELEM_W = 5,
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] log2e,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [ELEM_W-1:0] elem_i,
  output logic [ADDR_W-1:0] idx,
  output logic              err
);

  localparam int SUM_W = ADDR_W + REG_W + ELEM_W;

  logic [SUM_W-1:0] reg_part;
  logic [SUM_W-1:0] elem_hi;
  logic             reg_over;
  logic             elem_over;

  always_comb begin
    reg_part  = SUM_W'(reg_i) << log2e;
    elem_hi   = SUM_W'(elem_i) >> log2e;
    elem_over = (elem_hi != '0);
    reg_over  = (reg_part[SUM_W-1:ADDR_W] != '0);
    idx       = reg_part[ADDR_W-1:0] | ADDR_W'(elem_i);
    err       = reg_over || elem_over;
  end

endmodule

// File: rtl/vrf_store.sv
module vrf_store #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8,
  parameter int N_RD   = 5,
  parameter int N_WR   = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_WR-1:0]               wr_ok,
  input  logic [N_WR-1:0][ADDR_W-1:0]   wr_idx,
  input  logic [N_WR-1:0][DATA_W-1:0]   wr_data,
  input  logic [N_RD-1:0]               rd_en,
  input  logic [N_RD-1:0]               rd_bad,
  input  logic [N_RD-1:0][ADDR_W-1:0]   rd_idx,
  output logic [N_RD-1:0][DATA_W-1:0]   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [N_RD-1:0][DATA_W-1:0] fwd;

  // Later ports are applied last, so the highest-numbered writer wins.
  always_ff @(posedge clk) begin
    for (int w = 0; w < N_WR; w++) begin
      if (wr_ok[w]) mem[wr_idx[w]] <= wr_data[w];
    end
  end

  always_comb begin
    for (int r = 0; r < N_RD; r++) begin
      fwd[r] = mem[rd_idx[r]];
      for (int w = 0; w < N_WR; w++) begin
        if (wr_ok[w] && (wr_idx[w] == rd_idx[r])) fwd[r] = wr_data[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      for (int r = 0; r < N_RD; r++) begin
        if (rd_en[r]) rd_data[r] <= rd_bad[r] ? '0 : fwd[r];
      end
    end
  end

endmodule

// File: rtl/vrf_top.sv
module vrf_top #(
  parameter int DATA_W    = 64,
  parameter int ADDR_W    = 8,
  parameter int REG_W     = 5,
  parameter int ELEM_W    = 5,
  parameter int CODE_W    = 3,
  parameter int LOG2E_MIN = 3,
  parameter int LOG2E_MAX = 5,
  parameter int VL_W      = LOG2E_MAX + 1,
  parameter int N_RD      = 5,
  parameter int N_WR      = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_set,
  input  logic [CODE_W-1:0]           cfg_code,
  output logic [VL_W-1:0]             vlmax,
  input  logic [N_RD-1:0]             rd_en,
  input  logic [N_RD-1:0][REG_W-1:0]  rd_reg,
  input  logic [N_RD-1:0][ELEM_W-1:0] rd_elem,
  output logic [N_RD-1:0][DATA_W-1:0] rd_data,
  output logic [N_RD-1:0]             rd_err,
  input  logic [N_WR-1:0]             wr_en,
  input  logic [N_WR-1:0][REG_W-1:0]  wr_reg,
  input  logic [N_WR-1:0][ELEM_W-1:0] wr_elem,
  input  logic [N_WR-1:0][DATA_W-1:0] wr_data,
  output logic [N_WR-1:0]             wr_err
);

  logic [CODE_W-1:0]             log2e;
  logic                          busy;
  logic [N_RD-1:0][ADDR_W-1:0]   rd_idx;
  logic [N_RD-1:0]               rd_bad;
  logic [N_WR-1:0][ADDR_W-1:0]   wr_idx;
  logic [N_WR-1:0]               wr_bad;
  logic [N_WR-1:0]               wr_ok;

  always_comb begin
    busy  = (|rd_en) || (|wr_en);
    wr_ok = wr_en & ~wr_bad;
  end

  vrf_cfg #(
    .CODE_W(CODE_W), .VL_W(VL_W),
    .LOG2E_MIN(LOG2E_MIN), .LOG2E_MAX(LOG2E_MAX)
  ) u_cfg (
    .clk(clk), .rst(rst), .set_req(cfg_set), .busy(busy),
    .code(cfg_code), .log2e_q(log2e), .vlmax_q(vlmax)
  );

  for (genvar r = 0; r < N_RD; r++) begin : g_rd_map
    vrf_addr_map #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ELEM_W(ELEM_W), .CODE_W(CODE_W)
    ) u_map (
      .log2e(log2e), .reg_i(rd_reg[r]), .elem_i(rd_elem[r]),
      .idx(rd_idx[r]), .err(rd_bad[r])
    );
  end

  for (genvar w = 0; w < N_WR; w++) begin : g_wr_map
    vrf_addr_map #(
      .ADDR_W(ADDR_W), .REG_W(REG_W), .ELEM_W(ELEM_W), .CODE_W(CODE_W)
    ) u_map (
      .log2e(log2e), .reg_i(wr_reg[w]), .elem_i(wr_elem[w]),
      .idx(wr_idx[w]), .err(wr_bad[w])
    );
  end

  vrf_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RD(N_RD), .N_WR(N_WR)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_ok(wr_ok), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_en(rd_en), .rd_bad(rd_bad), .rd_idx(rd_idx),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_err <= '0;
      wr_err <= '0;
    end else begin
      rd_err <= rd_en & rd_bad;
      wr_err <= wr_en & wr_bad;
    end
  end

endmodule

// File: rtl/vrf_checker.sv
module vrf_checker #(
  parameter int DATA_W    = 64,
  parameter int LOG2E_MIN = 3,
  parameter int VL_W      = 6,
  parameter int N_RD      = 5,
  parameter int N_WR      = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cfg_set,
  input logic [VL_W-1:0]             vlmax,
  input logic [N_RD-1:0]             rd_en,
  input logic [N_RD-1:0][DATA_W-1:0] rd_data,
  input logic [N_RD-1:0]             rd_err,
  input logic [N_WR-1:0]             wr_en,
  input logic [N_WR-1:0]             wr_err
);

  p_reset_state_r1: assert property (@(posedge clk)
    $fell(rst) |-> (vlmax == (VL_W'(1) << LOG2E_MIN)) && (rd_err == '0) &&
                   (wr_err == '0) && (rd_data == '0));

  p_vlmax_shape_r2: assert property (@(posedge clk) disable iff (rst)
    (vlmax == VL_W'(8)) || (vlmax == VL_W'(16)) || (vlmax == VL_W'(32)));

  p_busy_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg_set && ((|rd_en) || (|wr_en))) |=> $stable(vlmax));

  p_no_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !cfg_set |=> $stable(vlmax));

  for (genvar r = 0; r < N_RD; r++) begin : g_rd_chk
    p_err_zero_data_r6: assert property (@(posedge clk) disable iff (rst)
      rd_err[r] |-> (rd_data[r] == '0));

    p_idle_read_hold_r11: assert property (@(posedge clk) disable iff (rst)
      !rd_en[r] |=> (!rd_err[r] && $stable(rd_data[r])));
  end

  for (genvar w = 0; w < N_WR; w++) begin : g_wr_chk
    p_idle_write_clear_r11: assert property (@(posedge clk) disable iff (rst)
      !wr_en[w] |=> !wr_err[w]);
  end

endmodule

bind vrf_top vrf_checker #(
  .DATA_W(DATA_W), .LOG2E_MIN(LOG2E_MIN), .VL_W(VL_W),
  .N_RD(N_RD), .N_WR(N_WR)
) u_vrf_checker (.*);

// File: tb/test_vrf_top.sv
`timescale 1ns/1ps
module test_vrf_top;

  logic                  clk = 1'b0;
  logic                  rst;
  logic                  cfg_set;
  logic [2:0]            cfg_code;
  logic [5:0]            vlmax;
  logic [4:0]            rd_en;
  logic [4:0][4:0]       rd_reg;
  logic [4:0][4:0]       rd_elem;
  logic [4:0][63:0]      rd_data;
  logic [4:0]            rd_err;
  logic [2:0]            wr_en;
  logic [2:0][4:0]       wr_reg;
  logic [2:0][4:0]       wr_elem;
  logic [2:0][63:0]      wr_data;
  logic [2:0]            wr_err;

  int total = 0;
  int bad   = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  vrf_top i_vrf_top (
    .clk(clk), .rst(rst), .cfg_set(cfg_set), .cfg_code(cfg_code),
    .vlmax(vlmax), .rd_en(rd_en), .rd_reg(rd_reg), .rd_elem(rd_elem),
    .rd_data(rd_data), .rd_err(rd_err), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_elem(wr_elem), .wr_data(wr_data), .wr_err(wr_err)
  );

  localparam logic [63:0] D0 = 64'h1111_0000_0000_0001;
  localparam logic [63:0] D1 = 64'h2222_0000_0000_00FF;
  localparam logic [63:0] D2 = 64'h3333_0000_0000_0018;
  localparam logic [63:0] D3 = 64'h4444_0000_0000_002B;
  localparam logic [63:0] DX = 64'hDEAD_BEEF_DEAD_BEEF;

  typedef struct packed {
    logic        is_wr;
    logic [2:0]  port;
    logic [4:0]  rg;
    logic [4:0]  el;
    logic [63:0] dat;
    logic        err;
  } row_t;

  // Shape is 32 regs x 8 elements throughout the table.
  localparam row_t TBL [10] = '{
    '{1'b1, 3'd0, 5'd0,  5'd0, D0, 1'b0},
    '{1'b1, 3'd1, 5'd31, 5'd7, D1, 1'b0},
    '{1'b1, 3'd2, 5'd3,  5'd0, D2, 1'b0},
    '{1'b1, 3'd0, 5'd2,  5'd8, DX, 1'b1},  // would alias reg 3 elem 0
    '{1'b0, 3'd0, 5'd0,  5'd0, D0, 1'b0},
    '{1'b0, 3'd1, 5'd31, 5'd7, D1, 1'b0},
    '{1'b0, 3'd4, 5'd3,  5'd0, D2, 1'b0},
    '{1'b0, 3'd2, 5'd2,  5'd8, 64'd0, 1'b1},
    '{1'b1, 3'd1, 5'd5,  5'd3, D3, 1'b0},
    '{1'b0, 3'd3, 5'd5,  5'd3, D3, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    cfg_set = 1'b0; cfg_code = 3'd0;
    rd_en = '0; rd_reg = '0; rd_elem = '0;
    wr_en = '0; wr_reg = '0; wr_elem = '0; wr_data = '0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd(input int p, input int rg, input int el);
    rd_en[p] = 1'b1; rd_reg[p] = 5'(rg); rd_elem[p] = 5'(el);
  endtask

  task automatic wr(input int p, input int rg, input int el, input logic [63:0] d);
    wr_en[p] = 1'b1; wr_reg[p] = 5'(rg); wr_elem[p] = 5'(el); wr_data[p] = d;
  endtask

  task automatic set_cfg(input int code, input logic keep_busy);
    idle();
    cfg_set = 1'b1; cfg_code = 3'(code);
    if (keep_busy) rd(0, 0, 0);
    step();
    idle();
  endtask

  initial begin
    rst = 1'b1;
    idle();
    repeat (3) step();
    rst = 1'b0;
    // R1: outputs still show reset values
    chk("R1 vlmax", 64'(vlmax), 64'd8);
    chk("R1 rd_data", 64'(rd_data[0] | rd_data[4]), 64'd0);
    chk("R1 err", 64'({rd_err, wr_err}), 64'd0);
    step();

    // R4 R5 R6 R7: table of single-port accesses
    for (int i = 0; i < 10; i++) begin
      idle();
      if (TBL[i].is_wr) wr(int'(TBL[i].port), int'(TBL[i].rg), int'(TBL[i].el), TBL[i].dat);
      else rd(int'(TBL[i].port), int'(TBL[i].rg), int'(TBL[i].el));
      step();
      if (TBL[i].is_wr) begin
        chk($sformatf("R7 wr_err row %0d", i), 64'(wr_err[TBL[i].port]), 64'(TBL[i].err));
      end else begin
        chk($sformatf("R6 rd_err row %0d", i), 64'(rd_err[TBL[i].port]), 64'(TBL[i].err));
        chk($sformatf("R5 rd_data row %0d", i), rd_data[TBL[i].port], TBL[i].dat);
      end
    end

    // R11: idle port holds data and clears errors
    idle(); step();
    chk("R11 hold data", rd_data[3], D3);
    chk("R11 rd_err clear", 64'(rd_err), 64'd0);
    chk("R11 wr_err clear", 64'(wr_err), 64'd0);

    // R8: same-cycle write forwarded to read (reg5 elem3)
    idle(); wr(0, 5, 3, 64'hF0F0); rd(2, 5, 3); step();
    chk("R8 forward", rd_data[2], 64'hF0F0);

    // R9: colliding writes, highest port wins
    idle(); wr(0, 6, 1, 64'hA0); wr(2, 6, 1, 64'hA2); rd(1, 6, 1); step();
    chk("R9 forward priority", rd_data[1], 64'hA2);
    idle(); rd(0, 6, 1); step();
    chk("R9 load port wins", rd_data[0], 64'hA2);
    idle(); wr(0, 6, 2, 64'hB0); wr(1, 6, 2, 64'hB1); step();
    idle(); rd(4, 6, 2); step();
    chk("R9 port1 beats port0", rd_data[4], 64'hB1);

    // R3: busy and illegal codes ignored
    set_cfg(5, 1'b1); step();
    chk("R3 busy ignored", 64'(vlmax), 64'd8);
    set_cfg(6, 1'b0); step();
    chk("R3 code 6 ignored", 64'(vlmax), 64'd8);
    set_cfg(2, 1'b0);
    chk("R3 code 2 ignored", 64'(vlmax), 64'd8);

    // R2: shape 8 regs x 32 elements
    set_cfg(5, 1'b0);
    chk("R2 vlmax 32", 64'(vlmax), 64'd32);
    // R4: entry 24 is reg0 elem24, entry 255 is reg7 elem31
    idle(); rd(0, 0, 24); rd(1, 7, 31); rd(2, 8, 0); step();
    chk("R4 alias 24", rd_data[0], D2);
    chk("R4 alias 255", rd_data[1], D1);
    chk("R6 reg 8 of 8", 64'(rd_err[2]), 64'd1);

    // R2: shape 16 regs x 16 elements
    set_cfg(4, 1'b0);
    chk("R2 vlmax 16", 64'(vlmax), 64'd16);
    idle(); rd(0, 1, 8); rd(1, 0, 16); step();
    chk("R4 alias reg1 elem8", rd_data[0], D2);
    chk("R6 elem 16 of 16", 64'(rd_err[1]), 64'd1);
    chk("R6 zero data", rd_data[1], 64'd0);

    // R10: all ports in use together
    idle(); wr(0, 0, 0, 64'hC0); wr(1, 1, 1, 64'hC1); wr(2, 2, 2, 64'hC2); step();
    chk("R10 no wr_err", 64'(wr_err), 64'd0);
    idle(); rd(0, 0, 0); rd(1, 1, 1); rd(2, 2, 2); rd(3, 15, 15); rd(4, 1, 8); step();
    chk("R10 port0", rd_data[0], 64'hC0);
    chk("R10 port1", rd_data[1], 64'hC1);
    chk("R10 port2", rd_data[2], 64'hC2);
    chk("R10 port3", rd_data[3], D1);
    chk("R10 port4", rd_data[4], D2);

    idle(); step();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule